// File: doc/BRIEF.md
# Endpoint Control Register File

This block holds one 16-bit control and status word per endpoint of a full-speed USB device controller. Software reaches the words through a simple register bus. A protocol engine reads them through a flat output vector and reports its own events on per-endpoint strobe inputs. Each word carries the endpoint address, the transfer type, a kind bit and a setup-seen flag. For each direction it also carries a completion flag, a data-toggle bit and a two-bit handshake state.

Bits inside one word follow different write rules. The handshake states and data toggles invert where a 1 is written. The completion flags can only be cleared by software. The type, kind and address fields are plain storage. Because of this, software can change one field with a single write and never overwrites a bit that the engine changed between the software's read and its write. Engine events are applied in the same cycle as a bus write and take precedence where the two conflict.

Top module: `ep_csr_bank`

## Requirements
- R1: After a synchronous active-low reset, every endpoint word reads 0x0000.
- R2: The word of endpoint n is reached at byte address n*4. An address whose two low bits are not zero, or whose index n is 8 or more, reads 0x0000 and ignores writes.
- R3: Bits 10:9 (type: 0 bulk, 1 control, 2 isochronous, 3 interrupt), bit 8 (kind) and bits 3:0 (endpoint address) take the written value.
- R4: The receive state in bits 13:12 and the transmit state in bits 5:4 (0 disabled, 1 STALL, 2 NAK, 3 VALID) are XORed with the written value. Writing 0 leaves them unchanged.
- R5: The receive toggle in bit 14 and the transmit toggle in bit 6 invert where a 1 is written and hold where a 0 is written.
- R6: The receive-complete flag in bit 15 and the transmit-complete flag in bit 7 are cleared by writing 0 and are unchanged by writing 1. Software cannot set them.
- R7: A receive or transmit completion event sets that direction's completion flag and inverts that direction's toggle. If the same cycle also has a software toggle write, both inversions apply.
- R8: When a completion event and a software clear of the same flag happen in one cycle, the flag ends up set.
- R9: A setup event sets bit 11. A write with bit 15 at 0 clears bit 11. Bit 11 of the written data is otherwise ignored.
- R10: A write changes only the addressed endpoint's word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register bus access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| ev_rx_done | input | 8 | Per-endpoint receive completion strobe |
| ev_tx_done | input | 8 | Per-endpoint transmit completion strobe |
| ev_setup | input | 8 | Per-endpoint setup reception strobe |
| csr_flat | output | 128 | All endpoint words, endpoint n in bits 16n+15:16n |

## Verification
A corrupted field in a slot shows up on the next read of that endpoint, one cycle after the write or event that caused it. The same fault is visible on csr_flat in that cycle. Toggle faults are the subtle case. A lost or doubled inversion, whether from a write or from an event, only shows as the wrong bit value on the read that follows. For this reason the bench reads back the word after every write and every event. It also combines events with writes in the same cycle, so that an error in precedence or in how the XOR terms add up becomes visible.

// File: rtl/ep_csr_pkg.sv
// Package: ep_csr_pkg
// Purpose: shared layout of one endpoint control/status word.
// Assumes: the field order below is the software-visible bit order.
package ep_csr_pkg;

    localparam int WORD_W = 16;

    // Endpoint word, MSB first: bit 15 down to bit 0.
    typedef struct packed {
        logic       rx_cmp;    // 15 receive complete, clear-by-zero
        logic       rx_tog;    // 14 receive data toggle, invert-by-one
        logic [1:0] rx_state;  // 13:12 receive handshake state, invert-by-one
        logic       setup;     // 11 setup seen, hardware set
        logic [1:0] ep_type;   // 10:9 transfer type, plain
        logic       kind;      // 8 kind, plain
        logic       tx_cmp;    // 7 transmit complete, clear-by-zero
        logic       tx_tog;    // 6 transmit data toggle, invert-by-one
        logic [1:0] tx_state;  // 5:4 transmit handshake state, invert-by-one
        logic [3:0] ep_addr;   // 3:0 endpoint address, plain
    } csr_t;

    // Handshake state codes: 0 disabled, 1 STALL, 2 NAK, 3 VALID.
    // Type codes: 0 bulk, 1 control, 2 isochronous, 3 interrupt.

endpackage

// File: rtl/ep_addr_decode.sv
// Module: ep_addr_decode
// Purpose: turns a byte address into an endpoint index, a hit flag and
//          one-hot write enables.
// Assumes: words are 4 bytes apart; misaligned or out-of-range addresses miss.
module ep_addr_decode #(
    parameter int N_EP   = 8,
    parameter int ADDR_W = 6,
    localparam int IDX_W = ADDR_W - 2
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [IDX_W-1:0]  idx,
    output logic              hit,
    output logic [N_EP-1:0]   wr_en
);

    // Index extraction and range/alignment check.
    always_comb begin
        idx = bus_addr[ADDR_W-1:2];
        hit = (bus_addr[1:0] == 2'b00) && (32'(idx) < N_EP);
    end

    // One write enable per slot.
    always_comb begin
        wr_en = '0;
        for (int i = 0; i < N_EP; i++) begin
            wr_en[i] = bus_sel && bus_wr && hit && (32'(idx) == i);
        end
    end

    // At most one slot is written per cycle.
    always_comb begin
        AST_ONE_SLOT: assert ($onehot0(wr_en)); // R10
    end

endmodule

// File: rtl/ep_csr_slot.sv
// Module: ep_csr_slot
// Purpose: one endpoint word with per-field write rules and event inputs.
// Assumes: events are single-cycle strobes. Events win over software clears,
//          and toggle inversions from software and events add as XOR.
module ep_csr_slot
    import ep_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    input  logic              ev_rx_done,
    input  logic              ev_tx_done,
    input  logic              ev_setup,
    output csr_t              q
);

    csr_t w;
    csr_t d;

    assign w = csr_t'(wdata);

    // Next-state: software write rules first, then hardware events on top.
    always_comb begin
        d = q;
        if (wr_en) begin
            d.rx_state = q.rx_state ^ w.rx_state;
            d.tx_state = q.tx_state ^ w.tx_state;
            d.rx_tog   = q.rx_tog ^ w.rx_tog;
            d.tx_tog   = q.tx_tog ^ w.tx_tog;
            d.ep_type  = w.ep_type;
            d.kind     = w.kind;
            d.ep_addr  = w.ep_addr;
            if (!w.rx_cmp) begin
                d.rx_cmp = 1'b0;
                d.setup  = 1'b0;
            end
            if (!w.tx_cmp) begin
                d.tx_cmp = 1'b0;
            end
        end
        if (ev_rx_done) begin
            d.rx_cmp = 1'b1;
            d.rx_tog = ~d.rx_tog;
        end
        if (ev_tx_done) begin
            d.tx_cmp = 1'b1;
            d.tx_tog = ~d.tx_tog;
        end
        if (ev_setup) begin
            d.setup = 1'b1;
        end
    end

    // Word register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> (q == '0)); // R1
    AST_PLAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(q.ep_type) && $stable(q.kind) && $stable(q.ep_addr))); // R3
    AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(q.rx_state) && $stable(q.tx_state))); // R4
    AST_RXTOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !ev_rx_done) |=> $stable(q.rx_tog)); // R5
    AST_TXTOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !ev_tx_done) |=> $stable(q.tx_tog)); // R5
    AST_RXCMP_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_rx_done |=> !$rose(q.rx_cmp)); // R6
    AST_TXCMP_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_tx_done |=> !$rose(q.tx_cmp)); // R6
    AST_RX_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_done |=> q.rx_cmp); // R8
    AST_TX_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_done |=> q.tx_cmp); // R8
    AST_SETUP_HW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && w.setup && !ev_setup && !q.setup) |=> !q.setup); // R9
    AST_SETUP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !w.rx_cmp && !ev_setup) |=> !q.setup); // R9

endmodule

// File: rtl/ep_read_mux.sv
// Module: ep_read_mux
// Purpose: selects the addressed endpoint word for the read bus.
// Assumes: a miss or an idle bus reads zero.
module ep_read_mux
    import ep_csr_pkg::*;
#(
    parameter int N_EP  = 8,
    parameter int IDX_W = 4
) (
    input  csr_t              slots [N_EP],
    input  logic [IDX_W-1:0]  idx,
    input  logic              hit,
    input  logic              bus_sel,
    output logic [WORD_W-1:0] rdata
);

    // Word selection by index.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_EP; i++) begin
            if (bus_sel && hit && (32'(idx) == i)) rdata = slots[i];
        end
    end

endmodule

// File: rtl/ep_csr_bank.sv
// Module: ep_csr_bank
// Purpose: bank of endpoint control/status words on a simple register bus,
//          with event strobes from a protocol engine.
// Assumes: bus writes take effect at the clock edge; reads are combinational.
module ep_csr_bank
    import ep_csr_pkg::*;
#(
    parameter int N_EP   = 8,
    parameter int ADDR_W = 6,
    localparam int IDX_W = ADDR_W - 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_sel,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [WORD_W-1:0]      bus_wdata,
    output logic [WORD_W-1:0]      bus_rdata,
    input  logic [N_EP-1:0]        ev_rx_done,
    input  logic [N_EP-1:0]        ev_tx_done,
    input  logic [N_EP-1:0]        ev_setup,
    output logic [N_EP*WORD_W-1:0] csr_flat
);

    logic [IDX_W-1:0] idx;
    logic             hit;
    logic [N_EP-1:0]  wr_en;
    csr_t             slots [N_EP];

    ep_addr_decode #(.N_EP(N_EP), .ADDR_W(ADDR_W)) u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .idx      (idx),
        .hit      (hit),
        .wr_en    (wr_en)
    );

    // One slot per endpoint; flatten for the protocol engine.
    for (genvar g = 0; g < N_EP; g++) begin : g_slot
        ep_csr_slot u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (wr_en[g]),
            .wdata      (bus_wdata),
            .ev_rx_done (ev_rx_done[g]),
            .ev_tx_done (ev_tx_done[g]),
            .ev_setup   (ev_setup[g]),
            .q          (slots[g])
        );
        assign csr_flat[g*WORD_W +: WORD_W] = slots[g];
    end

    ep_read_mux #(.N_EP(N_EP), .IDX_W(IDX_W)) u_rmux (
        .slots   (slots),
        .idx     (idx),
        .hit     (hit),
        .bus_sel (bus_sel),
        .rdata   (bus_rdata)
    );

endmodule

// File: tb/sim_ep_csr_bank.sv
module sim_ep_csr_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  ev_rx_done = '0;
    logic [7:0]  ev_tx_done = '0;
    logic [7:0]  ev_setup = '0;
    logic [127:0] csr_flat;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ep_csr_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_rx_done(ev_rx_done), .ev_tx_done(ev_tx_done), .ev_setup(ev_setup),
        .csr_flat(csr_flat)
    );

    // Vector: {addr, do_write, wdata, expected read-back}
    localparam int NV = 9;
    localparam logic [38:0] VEC [NV] = '{
        {6'h00, 1'b1, 16'h070F, 16'h070F},  // plain fields
        {6'h00, 1'b1, 16'h373F, 16'h373F},  // both states 0 -> 3
        {6'h00, 1'b1, 16'h172F, 16'h271F},  // rx 3^1=2, tx 3^2=1
        {6'h04, 1'b1, 16'h4040, 16'h4040},  // toggles flip on
        {6'h04, 1'b1, 16'hC0C0, 16'h0000},  // toggles flip off, flags stay 0
        {6'h1C, 1'b1, 16'h0205, 16'h0205},  // last endpoint at 7*4
        {6'h20, 1'b1, 16'h0333, 16'h0000},  // index 8: miss
        {6'h00, 1'b0, 16'h0000, 16'h271F},  // ep0 untouched by others
        {6'h1C, 1'b0, 16'h0000, 16'h0205}   // ep7 untouched by others
    };
    localparam string TAG [NV] = '{"R3", "R4", "R4", "R5", "R6", "R2", "R2", "R10", "R10"};

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] rx, input logic [7:0] tx, input logic [7:0] su);
        @(negedge clk);
        ev_rx_done = rx; ev_tx_done = tx; ev_setup = su;
        @(negedge clk);
        ev_rx_done = '0; ev_tx_done = '0; ev_setup = '0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: all words zero after reset.
        for (int i = 0; i < 8; i++) begin
            bus_read(6'(i * 4), rd);
            check("R1", rd, 16'h0000);
        end

        // Table walk.
        for (int v = 0; v < NV; v++) begin
            if (VEC[v][32]) bus_write(VEC[v][38:33], VEC[v][31:16]);
            bus_read(VEC[v][38:33], rd);
            check(TAG[v], rd, VEC[v][15:0]);
        end

        // R2: misaligned write to ep6 is ignored and misaligned read gives 0.
        bus_write(6'h19, 16'h0305);
        bus_read(6'h18, rd);
        check("R2", rd, 16'h0000);
        bus_write(6'h18, 16'h0001);
        bus_read(6'h1A, rd);
        check("R2", rd, 16'h0000);

        // R7: receive completion on ep1 sets flag and flips toggle.
        pulse(8'h02, 8'h00, 8'h00);
        bus_read(6'h04, rd);
        check("R7", rd, 16'hC000);
        // R6: writing 1 to the flag keeps it; writing 0 clears it.
        bus_write(6'h04, 16'h8000);
        bus_read(6'h04, rd);
        check("R6", rd, 16'hC000);
        bus_write(6'h04, 16'h0000);
        bus_read(6'h04, rd);
        check("R6", rd, 16'h4000);

        // R7: transmit completion on ep2.
        pulse(8'h00, 8'h04, 8'h00);
        bus_read(6'h08, rd);
        check("R7", rd, 16'h00C0);

        // R8 with R7: event plus clear plus toggle write in one cycle.
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h08; bus_wdata = 16'h0040;
        ev_tx_done = 8'h04;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; ev_tx_done = '0;
        bus_read(6'h08, rd);
        check("R8", rd, 16'h00C0);

        // R9: setup with receive completion on ep3, then a clear via bit 15 = 0.
        pulse(8'h08, 8'h00, 8'h08);
        bus_read(6'h0C, rd);
        check("R9", rd, 16'hC800);
        bus_write(6'h0C, 16'h0800);
        bus_read(6'h0C, rd);
        check("R9", rd, 16'h4000);

        // R9: setup on ep4 survives a write with bit 15 = 1.
        pulse(8'h00, 8'h00, 8'h10);
        bus_write(6'h10, 16'h8000);
        bus_read(6'h10, rd);
        check("R9", rd, 16'h0800);

        // R9: software cannot set bit 11 on ep5.
        bus_write(6'h14, 16'h8800);
        bus_read(6'h14, rd);
        check("R9", rd, 16'h0000);

        // R10: flat view keeps ep0 and ep7 after all of the above.
        @(negedge clk);
        check("R10", csr_flat[15:0], 16'h271F);
        check("R10", csr_flat[127:112], 16'h0205);

        finish_run();
    end

endmodule